// File: doc/BRIEF.md
# Sequential Configuration Register Loader

This block holds a bank of ten 8-bit configuration registers that are filled from a parallel data bus. The writes carry no address. An internal sequence counter picks the target register, and it starts at register 1. Each rising clock edge on which the active-low load strobe and the active-low write enable are both asserted stores the bus byte into the current register. The counter then moves to the next register.

When the load strobe is released, the counter returns to register 1. After register 10 has been written, the counter wraps back to register 1. Some registers reset to non-zero values: registers 4 and 7 to 0x7F, and register 10 to 0x80. All the others reset to 0x00.

Three controls are decoded from the bank and driven as outputs:
- a queue-enable bit,
- a 3-bit queue-count field,
- a fast-clock bit.

All other bits are reserved. They are stored as written but drive nothing. A one-cycle update pulse follows every write, so that downstream logic can take up the new settings.

Top module: `cfg_seq_loader`

## Requirements
- R1: A register is written on a rising clock edge only when `load_n` and `wr_n` are both low at that edge. Any other combination writes nothing.
- R2: Qualifying edges write registers in the order 1, 2, 3 and onward to 10, starting from register 1 after reset.
- R3: A clock edge with `load_n` high writes nothing. It returns the sequence so that the next qualifying edge writes register 1.
- R4: After register 10 is written, the next qualifying edge writes register 1.
- R5: An edge with `load_n` low and `wr_n` high pauses the sequence. Nothing is written, and the next qualifying edge writes the register that would have been written.
- R6: `queue_en` equals bit 7 of register 3, and `queue_cnt` equals bits 2:0 of register 3. Both outputs are updated at the edge that writes the register.
- R7: `fast_clk` equals bit 7 of register 10, updated at the edge that writes it.
- R8: Bits 6:3 of register 3, bits 6:0 of register 10, and all bits of the other registers have no effect on any output.
- R9: `update_pulse` is high for exactly the one cycle that follows each write edge, and low otherwise.
- R10: While `rst` is high at a clock edge, the block restores all defaults. After reset, `queue_en`=0, `queue_cnt`=0, `fast_clk`=1 and `update_pulse`=0, and the next qualifying edge writes register 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| load_n | input | 1 | Load strobe, active low; high restarts the sequence |
| wr_n | input | 1 | Write enable, active low |
| din | input | 8 | Parallel data bus |
| queue_en | output | 1 | Queue-enable control (register 3 bit 7) |
| queue_cnt | output | 3 | Queue-count field (register 3 bits 2:0) |
| fast_clk | output | 1 | Fast-clock control (register 10 bit 7) |
| update_pulse | output | 1 | High for one cycle after each write |

## Verification
The embedded assertions check several properties on every cycle:
- the update pulse follows exactly the write edges,
- no register changes unless it is the selected target,
- at most one register is selected,
- the counter returns to register 1 on a strobe release or after the last register,
- the outputs hold during a pause.

Other behaviours show only in the bench's scenarios. These are:
- the order in which bus bytes land in particular registers,
- the wrap-around that brings register 3 round again,
- the masking of reserved bits,
- the reset values seen at the ports.

The bench reaches them through longer stimulus sequences.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;

  localparam int CFG_DATA_W   = 8;
  localparam int CFG_NUM_REGS = 10;

  // Zero-based register positions and bit fields that the decoder uses
  localparam int QCFG_IDX  = 2;   // register 3
  localparam int FAST_IDX  = 9;   // register 10
  localparam int QEN_BIT   = 7;
  localparam int QCNT_W    = 3;
  localparam int FAST_BIT  = 7;

  typedef logic [CFG_DATA_W-1:0] cfg_byte_t;

  // Reset value of each register, by zero-based index
  function automatic cfg_byte_t reg_default(input int idx);
    cfg_byte_t v;
    case (idx)
      3, 6:    v = cfg_byte_t'(8'h7F);
      FAST_IDX: v = cfg_byte_t'(8'h80);
      default: v = '0;
    endcase
    return v;
  endfunction

  // Next sequence slot, wrapping after the last register
  function automatic int next_slot(input int cur, input int num);
    return (cur >= num - 1) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/cfgld_seq_ctr.sv
module cfgld_seq_ctr #(
  parameter int NUM_REGS = 10,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             advance,
  output logic [IDX_W-1:0] idx,
  output logic             at_last
);
  import cfgld_pkg::*;

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

  logic [IDX_W-1:0] idx_next;

  assign at_last  = (idx == LAST_IDX);
  assign idx_next = IDX_W'(next_slot(int'(idx), NUM_REGS));

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      idx <= '0;
    end else if (advance) begin
      idx <= idx_next;
    end
  end

  // R3: releasing the strobe sends the sequence back to register 1
  a_r3_restart_to_first: assert property (@(posedge clk) disable iff (rst)
    restart |=> (idx == '0));

  // R4: writing the last register wraps to the first
  a_r4_wrap_after_last: assert property (@(posedge clk) disable iff (rst)
    (advance && !restart && at_last) |=> (idx == '0));

  // R5: a paused edge leaves the slot where it was
  a_r5_pause_holds_slot: assert property (@(posedge clk) disable iff (rst)
    (!advance && !restart) |=> $stable(idx));

  // R2: the slot never leaves the legal range
  a_r2_slot_in_range: assert property (@(posedge clk) disable iff (rst)
    idx <= LAST_IDX);

endmodule

// File: rtl/cfgld_reg_bank.sv
module cfgld_reg_bank #(
  parameter int NUM_REGS = 10,
  parameter int DATA_W   = 8,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             wr_fire,
  input  logic [IDX_W-1:0]                 wr_idx,
  input  logic [DATA_W-1:0]                wr_data,
  output logic [NUM_REGS-1:0][DATA_W-1:0]  regs
);
  import cfgld_pkg::*;

  logic [NUM_REGS-1:0] sel_vec;

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
    localparam logic [DATA_W-1:0] DEF = DATA_W'(reg_default(gi));

    assign sel_vec[gi] = wr_fire && (wr_idx == IDX_W'(gi));

    always_ff @(posedge clk) begin
      if (rst) begin
        regs[gi] <= DEF;
      end else if (sel_vec[gi]) begin
        regs[gi] <= wr_data;
      end
    end

    // R1: a register only changes on an edge that selects it
    a_r1_unselected_stable: assert property (@(posedge clk) disable iff (rst)
      !sel_vec[gi] |=> $stable(regs[gi]));
  end

  // R2: one register at most per write edge
  a_r2_single_target: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel_vec));

endmodule

// File: rtl/cfgld_decode.sv
module cfgld_decode #(
  parameter int NUM_REGS = 10,
  parameter int DATA_W   = 8
) (
  input  logic [NUM_REGS-1:0][DATA_W-1:0]  regs,
  output logic                             queue_en,
  output logic [cfgld_pkg::QCNT_W-1:0]     queue_cnt,
  output logic                             fast_clk
);
  import cfgld_pkg::*;

  // Only the named control bits leave the bank; reserved bits stay inside
  assign queue_en  = regs[QCFG_IDX][QEN_BIT];
  assign queue_cnt = regs[QCFG_IDX][QCNT_W-1:0];
  assign fast_clk  = regs[FAST_IDX][FAST_BIT];

endmodule

// File: rtl/cfg_seq_loader.sv
module cfg_seq_loader #(
  parameter int NUM_REGS = cfgld_pkg::CFG_NUM_REGS,
  parameter int DATA_W   = cfgld_pkg::CFG_DATA_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         load_n,
  input  logic                         wr_n,
  input  logic [DATA_W-1:0]            din,
  output logic                         queue_en,
  output logic [cfgld_pkg::QCNT_W-1:0] queue_cnt,
  output logic                         fast_clk,
  output logic                         update_pulse
);
  import cfgld_pkg::*;

  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic                            wr_fire;
  logic                            seq_restart;
  logic [IDX_W-1:0]                slot_idx;
  logic                            slot_last;
  logic [NUM_REGS-1:0][DATA_W-1:0] bank_q;

  assign wr_fire     = !load_n && !wr_n;
  assign seq_restart = load_n;

  cfgld_seq_ctr #(.NUM_REGS(NUM_REGS)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .restart (seq_restart),
    .advance (wr_fire),
    .idx     (slot_idx),
    .at_last (slot_last)
  );

  cfgld_reg_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_fire (wr_fire),
    .wr_idx  (slot_idx),
    .wr_data (din),
    .regs    (bank_q)
  );

  cfgld_decode #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_dec (
    .regs      (bank_q),
    .queue_en  (queue_en),
    .queue_cnt (queue_cnt),
    .fast_clk  (fast_clk)
  );

  always_ff @(posedge clk) begin
    if (rst) update_pulse <= 1'b0;
    else     update_pulse <= wr_fire;
  end

  // R9: every write edge is followed by a pulse
  a_r9_pulse_after_write: assert property (@(posedge clk) disable iff (rst)
    (!load_n && !wr_n) |=> update_pulse);

  // R9: no pulse without a preceding write edge
  a_r9_no_spurious_pulse: assert property (@(posedge clk) disable iff (rst)
    (load_n || wr_n) |=> !update_pulse);

  // R1 and R5: outputs hold across edges that write nothing
  a_r5_outputs_hold: assert property (@(posedge clk) disable iff (rst)
    (load_n || wr_n) |=> ($stable(queue_en) && $stable(queue_cnt) && $stable(fast_clk)));

  // R6 and R7: decoded controls move only on a write to their register
  a_r6_qcfg_on_its_slot: assert property (@(posedge clk) disable iff (rst)
    !(wr_fire && slot_idx == IDX_W'(QCFG_IDX)) |=> ($stable(queue_en) && $stable(queue_cnt)));

  a_r7_fast_on_its_slot: assert property (@(posedge clk) disable iff (rst)
    !(wr_fire && slot_last) |=> $stable(fast_clk));

endmodule

// File: tb/cfg_seq_loader_tb.sv
module cfg_seq_loader_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load_n = 1'b1;
  logic       wr_n = 1'b1;
  logic [7:0] din = '0;
  logic       queue_en;
  logic [2:0] queue_cnt;
  logic       fast_clk;
  logic       update_pulse;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  cfg_seq_loader u_dut (
    .clk(clk), .rst(rst), .load_n(load_n), .wr_n(wr_n), .din(din),
    .queue_en(queue_en), .queue_cnt(queue_cnt), .fast_clk(fast_clk),
    .update_pulse(update_pulse)
  );

  // {load_n, wr_n, din, exp queue_en, exp queue_cnt, exp fast_clk, exp pulse}
  localparam int NV = 20;
  localparam logic [15:0] VEC [NV] = '{
    {1'b1, 1'b1, 8'h00, 1'b0, 3'd0, 1'b1, 1'b0},  // idle
    {1'b0, 1'b0, 8'h11, 1'b0, 3'd0, 1'b1, 1'b1},  // reg1
    {1'b0, 1'b0, 8'h22, 1'b0, 3'd0, 1'b1, 1'b1},  // reg2
    {1'b0, 1'b0, 8'h85, 1'b1, 3'd5, 1'b1, 1'b1},  // reg3
    {1'b0, 1'b1, 8'hFF, 1'b1, 3'd5, 1'b1, 1'b0},  // pause
    {1'b0, 1'b0, 8'h00, 1'b1, 3'd5, 1'b1, 1'b1},  // reg4
    {1'b0, 1'b0, 8'hFF, 1'b1, 3'd5, 1'b1, 1'b1},  // reg5
    {1'b0, 1'b0, 8'hFF, 1'b1, 3'd5, 1'b1, 1'b1},  // reg6
    {1'b0, 1'b0, 8'hFF, 1'b1, 3'd5, 1'b1, 1'b1},  // reg7
    {1'b0, 1'b0, 8'hFF, 1'b1, 3'd5, 1'b1, 1'b1},  // reg8
    {1'b0, 1'b0, 8'hFF, 1'b1, 3'd5, 1'b1, 1'b1},  // reg9
    {1'b0, 1'b0, 8'h7F, 1'b1, 3'd5, 1'b0, 1'b1},  // reg10
    {1'b0, 1'b0, 8'hFF, 1'b1, 3'd5, 1'b0, 1'b1},  // wrap to reg1
    {1'b0, 1'b0, 8'hFF, 1'b1, 3'd5, 1'b0, 1'b1},  // reg2
    {1'b0, 1'b0, 8'h7A, 1'b0, 3'd2, 1'b0, 1'b1},  // reg3 again
    {1'b1, 1'b0, 8'h99, 1'b0, 3'd2, 1'b0, 1'b0},  // strobe high
    {1'b0, 1'b0, 8'h12, 1'b0, 3'd2, 1'b0, 1'b1},  // reg1
    {1'b0, 1'b0, 8'h34, 1'b0, 3'd2, 1'b0, 1'b1},  // reg2
    {1'b0, 1'b0, 8'hC3, 1'b1, 3'd3, 1'b0, 1'b1},  // reg3
    {1'b1, 1'b1, 8'h00, 1'b1, 3'd3, 1'b0, 1'b0}   // idle
  };

  task automatic check(input string req, input logic qe, input logic [2:0] qc,
                       input logic fc, input logic up);
    n_chk++;
    if (queue_en !== qe || queue_cnt !== qc || fast_clk !== fc || update_pulse !== up) begin
      n_fail++;
      $display("FAIL %s: got qen=%0b cnt=%0d fast=%0b pulse=%0b, expected qen=%0b cnt=%0d fast=%0b pulse=%0b",
               req, queue_en, queue_cnt, fast_clk, update_pulse, qe, qc, fc, up);
    end
  endtask

  // Drive at the falling edge, let one rising edge pass, sample at the next falling edge
  task automatic step(input logic l, input logic w, input logic [7:0] d);
    load_n = l; wr_n = w; din = d;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout, expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check("R10 reset defaults", 1'b0, 3'd0, 1'b1, 1'b0);
    rst = 1'b0;

    // Table walk: R1 R2 R3 R4 R5 R6 R7 R9
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][15], VEC[i][14], VEC[i][13:6]);
      check($sformatf("R2/R4/R6/R7/R9 vector %0d", i),
            VEC[i][5], VEC[i][4:2], VEC[i][1], VEC[i][0]);
    end

    // R8: reserved bits of register 3 change no output
    step(1'b0, 1'b0, 8'h00);
    step(1'b0, 1'b0, 8'h00);
    step(1'b0, 1'b0, 8'h78);
    check("R8 reserved bits reg3", 1'b0, 3'd0, 1'b0, 1'b1);
    // R8: reserved bits of register 10 change no output (reg4..reg10, 0x7F)
    for (int k = 4; k <= 10; k++) step(1'b0, 1'b0, 8'h7F);
    check("R8 reserved bits reg10", 1'b0, 3'd0, 1'b0, 1'b1);

    // R1: load_n low with wr_n high, and strobe high with wr_n high, write nothing
    step(1'b0, 1'b1, 8'hFF);
    check("R1 wr_n high no write", 1'b0, 3'd0, 1'b0, 1'b0);
    step(1'b1, 1'b1, 8'hFF);
    check("R1 both high no write", 1'b0, 3'd0, 1'b0, 1'b0);

    // R3: strobe high with wr_n low for several edges, then reg3 on third write
    for (int k = 0; k < 3; k++) step(1'b1, 1'b0, 8'hFF);
    check("R3 strobe high no write", 1'b0, 3'd0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 8'h00);
    step(1'b0, 1'b0, 8'h00);
    check("R3 reg2 write leaves reg3", 1'b0, 3'd0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 8'h86);
    check("R3 restart then reg3", 1'b1, 3'd6, 1'b0, 1'b1);

    // R10: mid-sequence reset restores defaults and restarts the order
    load_n = 1'b0; wr_n = 1'b0; din = 8'h00; rst = 1'b1;
    @(negedge clk);
    check("R10 reset during load", 1'b0, 3'd0, 1'b1, 1'b0);
    rst = 1'b0;
    step(1'b0, 1'b0, 8'h00);
    step(1'b0, 1'b0, 8'h00);
    step(1'b0, 1'b0, 8'h87);
    check("R10 sequence restarts at reg1", 1'b1, 3'd7, 1'b1, 1'b1);
    step(1'b1, 1'b1, 8'h00);
    check("R9 pulse drops after idle", 1'b1, 3'd7, 1'b1, 1'b0);

    finish_run();
  end

endmodule